// File: doc/BRIEF.md
# Parallel NOR Flash Program/Erase Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus. It takes a single request for one of three operations: write one word, erase one sector, or erase the whole array. It then plays the matching unlock write sequence onto the bus, with strobe widths set by parameters counted in clock cycles. The chip stays selected from the first write until the operation ends.

After the last write, the block releases the data bus and reads the affected location over and over. It watches data bit 6, which the flash flips on every read while its internal operation runs. The block declares completion only when the bit has stopped moving and two further reads confirm it, because a read can land at the same moment the internal operation finishes. Each operation kind has its own cycle budget for polling. If the budget runs out first, the block reports a timeout instead of done.

The bidirectional data bus is split into an output word, an output enable and an input word. The pad-level tri-state buffer is placed outside this block.

Top module: `pflash_wr_ctrl`

## Requirements
- R1: Out of reset and whenever not busy, chip select, write strobe and read strobe are all high (inactive), the data bus is released, the address output is 0, and busy, done and timeout are low.
- R2: A request is taken only while not busy, and only with operation code 0 (word write), 1 (sector erase) or 2 (full erase). Code 3 is ignored. Any request raised while busy is ignored and does not alter the sequence in progress.
- R3: Each bus write lasts T_WPH + T_WP cycles: first T_WPH cycles with the write strobe high, then T_WP cycles with it low. Address and data are held for the whole slot, the data bus is driven, the read strobe stays high, and chip select stays low.
- R4: Code 0 issues four writes, as (address/data): 5555h/00AAh, 2AAAh/0055h, 5555h/00A0h, then the requested address with the requested data.
- R5: Code 1 issues six writes: 5555h/00AAh, 2AAAh/0055h, 5555h/0080h, 5555h/00AAh, 2AAAh/0055h, then the sector base with 0030h. The sector base is the requested address with its low SECTOR_AW bits (default 11) cleared.
- R6: Code 2 issues the same first five writes as code 1, then 5555h/0010h.
- R7: Polling reads keep chip select low and the data bus released. Each read lasts T_RGAP cycles with the read strobe high, then T_RD cycles with it low. Bit 6 is sampled on the clock edge that ends the last low cycle. The read address is the written word's address, the sector base, or 5555h for a full erase.
- R8: Completion needs four successive reads with equal bit 6: one matching pair, then two confirming reads. Any read that differs from the one before it restarts the count.
- R9: On completion, done is high for exactly one cycle. In that same cycle busy is low and the bus is idle as in R1.
- R10: Polling may last at most TO_PROG, TO_SECT or TO_CHIP cycles for codes 0, 1 and 2. If completion has not happened by the end of the last allowed cycle, timeout pulses for one cycle, the bus goes idle, and done stays low. A completion in that very last cycle is reported as done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_op | input | 2 | Operation code: 0 word write, 1 sector erase, 2 full erase |
| req_addr | input | 16 | Target word address or any address inside the sector |
| req_data | input | 16 | Word to write (code 0 only) |
| busy | output | 1 | High from acceptance until the result cycle |
| done | output | 1 | One-cycle pulse: operation completed |
| timeout | output | 1 | One-cycle pulse: polling budget exhausted |
| fl_addr | output | 16 | Flash address bus |
| fl_dq_o | output | 16 | Flash data bus, outgoing value |
| fl_dq_oe | output | 1 | Drive enable for the flash data bus |
| fl_dq_i | input | 16 | Flash data bus, incoming value |
| fl_ce_n | output | 1 | Chip select, active low |
| fl_oe_n | output | 1 | Read strobe, active low |
| fl_we_n | output | 1 | Write strobe, active low |

## Verification
The bench targets read patterns that mimic a finish racing a poll: a pair of equal reads followed by a differing read, and a differing read arriving after two matches. A design that trusted the first equal pair would raise done several read slots early. The polling budget is set so that one case settles on exactly the last allowed cycle and another keeps toggling through it. An off-by-one budget would swap done and timeout, or shift the pulse by a cycle. A request injected mid-sequence and an unused operation code check that nothing is re-latched. A design that accepted either would show a changed address or data word on the very next cycle.

// File: rtl/pflash_pkg.sv
package pflash_pkg;

    localparam int AW = 16;
    localparam int DW = 16;
    localparam int TOGGLE_BIT = 6;
    localparam int CONFIRM_PAIRS = 3;

    localparam logic [AW-1:0] UNLOCK_ADDR_A = 16'h5555;
    localparam logic [AW-1:0] UNLOCK_ADDR_B = 16'h2AAA;
    localparam logic [DW-1:0] KEY_A = 16'h00AA;
    localparam logic [DW-1:0] KEY_B = 16'h0055;
    localparam logic [DW-1:0] CMD_WORD = 16'h00A0;
    localparam logic [DW-1:0] CMD_ERASE_SETUP = 16'h0080;
    localparam logic [DW-1:0] CMD_SECTOR = 16'h0030;
    localparam logic [DW-1:0] CMD_CHIP = 16'h0010;

    typedef enum logic [1:0] {
        OP_PROG = 2'd0,
        OP_SECT = 2'd1,
        OP_CHIP = 2'd2,
        OP_NONE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'b001,
        ST_WRITE = 3'b010,
        ST_POLL  = 3'b100
    } st_e;

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } bus_wr_t;

    function automatic logic [2:0] seq_len(op_e op);
        return (op == OP_PROG) ? 3'd4 : 3'd6;
    endfunction

    function automatic logic [AW-1:0] sector_base(logic [AW-1:0] a, int sect_aw);
        logic [AW-1:0] mask;
        mask = '1;
        mask = mask << sect_aw;
        return a & mask;
    endfunction

    function automatic bus_wr_t seq_word(op_e op, logic [2:0] idx,
                                         logic [AW-1:0] tgt, logic [DW-1:0] wdat,
                                         int sect_aw);
        bus_wr_t w;
        case (idx)
            3'd0: w = '{UNLOCK_ADDR_A, KEY_A};
            3'd1: w = '{UNLOCK_ADDR_B, KEY_B};
            3'd2: w = '{UNLOCK_ADDR_A, (op == OP_PROG) ? CMD_WORD : CMD_ERASE_SETUP};
            3'd3: w = (op == OP_PROG) ? '{tgt, wdat} : '{UNLOCK_ADDR_A, KEY_A};
            3'd4: w = '{UNLOCK_ADDR_B, KEY_B};
            default: w = (op == OP_SECT) ? '{sector_base(tgt, sect_aw), CMD_SECTOR}
                                         : '{UNLOCK_ADDR_A, CMD_CHIP};
        endcase
        return w;
    endfunction

    function automatic logic [AW-1:0] poll_addr(op_e op, logic [AW-1:0] tgt, int sect_aw);
        case (op)
            OP_PROG: return tgt;
            OP_SECT: return sector_base(tgt, sect_aw);
            default: return UNLOCK_ADDR_A;
        endcase
    endfunction

endpackage

// File: rtl/pflash_slot_timer.sv
module pflash_slot_timer #(
    parameter int LEN_A = 3,
    parameter int LEN_B = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic in_b,
    output logic last
);
    localparam int TOT = LEN_A + LEN_B;
    localparam int CW = $clog2(TOT + 1);
    localparam logic [CW-1:0] A_END = CW'(LEN_A);
    localparam logic [CW-1:0] T_END = CW'(TOT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == T_END) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign in_b = run && (cnt_q >= A_END);
    assign last = run && (cnt_q == T_END);
endmodule

// File: rtl/pflash_toggle_judge.sv
module pflash_toggle_judge #(
    parameter int AGREE_N = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic sample,
    input  logic bit_in,
    output logic settle
);
    localparam int CW = $clog2(AGREE_N + 1);
    localparam logic [CW-1:0] NEED = CW'(AGREE_N - 1);

    logic          have_prev_q;
    logic          prev_q;
    logic [CW-1:0] agree_q;
    logic          same;

    assign same = have_prev_q && (bit_in == prev_q);
    assign settle = sample && same && (agree_q == NEED);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            have_prev_q <= 1'b0;
            prev_q      <= 1'b0;
            agree_q     <= '0;
        end else if (sample) begin
            have_prev_q <= 1'b1;
            prev_q      <= bit_in;
            if (!same) begin
                agree_q <= '0;
            end else if (agree_q != NEED) begin
                agree_q <= agree_q + CW'(1);
            end
        end
    end
endmodule

// File: rtl/pflash_wr_ctrl.sv
module pflash_wr_ctrl
    import pflash_pkg::*;
#(
    parameter int T_WPH = 3,
    parameter int T_WP = 4,
    parameter int T_RGAP = 2,
    parameter int T_RD = 7,
    parameter int SECTOR_AW = 11,
    parameter int TO_PROG = 2000,
    parameter int TO_SECT = 2500000,
    parameter int TO_CHIP = 10000000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic [1:0]    req_op,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          busy,
    output logic          done,
    output logic          timeout,
    output logic [AW-1:0] fl_addr,
    output logic [DW-1:0] fl_dq_o,
    output logic          fl_dq_oe,
    input  logic [DW-1:0] fl_dq_i,
    output logic          fl_ce_n,
    output logic          fl_oe_n,
    output logic          fl_we_n
);
    localparam int TO_MAX_A = (TO_PROG > TO_SECT) ? TO_PROG : TO_SECT;
    localparam int TO_MAX = (TO_MAX_A > TO_CHIP) ? TO_MAX_A : TO_CHIP;
    localparam int TW = $clog2(TO_MAX + 1);

    function automatic logic [TW-1:0] lim_of(op_e o);
        case (o)
            OP_PROG: return TW'(TO_PROG);
            OP_SECT: return TW'(TO_SECT);
            default: return TW'(TO_CHIP);
        endcase
    endfunction

    st_e           st_q;
    op_e           op_q;
    op_e           req_kind;
    logic [AW-1:0] tgt_q;
    logic [DW-1:0] wdat_q;
    logic [2:0]    idx_q;
    logic [TW-1:0] tmr_q;
    logic [TW-1:0] lim_q;
    logic          done_q;
    logic          to_q;
    logic          wr_in_b, wr_last;
    logic          rd_in_b, rd_last;
    logic          settle;
    bus_wr_t       cur_wr;

    assign req_kind = op_e'(req_op);
    assign cur_wr = seq_word(op_q, idx_q, tgt_q, wdat_q, SECTOR_AW);

    pflash_slot_timer #(.LEN_A(T_WPH), .LEN_B(T_WP)) wr_tmr_i (
        .clk(clk), .rst(rst), .run(st_q == ST_WRITE),
        .in_b(wr_in_b), .last(wr_last)
    );

    pflash_slot_timer #(.LEN_A(T_RGAP), .LEN_B(T_RD)) rd_tmr_i (
        .clk(clk), .rst(rst), .run(st_q == ST_POLL),
        .in_b(rd_in_b), .last(rd_last)
    );

    pflash_toggle_judge #(.AGREE_N(CONFIRM_PAIRS)) judge_i (
        .clk(clk), .rst(rst), .clear(st_q != ST_POLL),
        .sample(rd_last), .bit_in(fl_dq_i[TOGGLE_BIT]), .settle(settle)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_IDLE;
            op_q   <= OP_PROG;
            tgt_q  <= '0;
            wdat_q <= '0;
            idx_q  <= '0;
            tmr_q  <= '0;
            lim_q  <= '0;
            done_q <= 1'b0;
            to_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            to_q   <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (req_valid && req_kind != OP_NONE) begin
                        op_q   <= req_kind;
                        tgt_q  <= req_addr;
                        wdat_q <= req_data;
                        idx_q  <= '0;
                        lim_q  <= lim_of(req_kind);
                        st_q   <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    if (wr_last) begin
                        if (idx_q == seq_len(op_q) - 3'd1) begin
                            st_q  <= ST_POLL;
                            tmr_q <= '0;
                        end else begin
                            idx_q <= idx_q + 3'd1;
                        end
                    end
                end
                ST_POLL: begin
                    tmr_q <= tmr_q + TW'(1);
                    if (settle) begin
                        st_q   <= ST_IDLE;
                        done_q <= 1'b1;
                    end else if (tmr_q == lim_q - TW'(1)) begin
                        st_q <= ST_IDLE;
                        to_q <= 1'b1;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        fl_ce_n  = 1'b1;
        fl_we_n  = 1'b1;
        fl_oe_n  = 1'b1;
        fl_dq_oe = 1'b0;
        fl_addr  = '0;
        fl_dq_o  = '0;
        case (st_q)
            ST_WRITE: begin
                fl_ce_n  = 1'b0;
                fl_we_n  = !wr_in_b;
                fl_dq_oe = 1'b1;
                fl_addr  = cur_wr.addr;
                fl_dq_o  = cur_wr.data;
            end
            ST_POLL: begin
                fl_ce_n = 1'b0;
                fl_oe_n = !rd_in_b;
                fl_addr = poll_addr(op_q, tgt_q, SECTOR_AW);
            end
            default: ;
        endcase
    end

    assign busy    = (st_q != ST_IDLE);
    assign done    = done_q;
    assign timeout = to_q;
endmodule

// File: rtl/pflash_wr_ctrl_chk.sv
module pflash_wr_ctrl_chk #(
    parameter int T_WP = 4
) (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        done,
    input logic        timeout,
    input logic        fl_ce_n,
    input logic        fl_we_n,
    input logic        fl_oe_n,
    input logic        fl_dq_oe,
    input logic [15:0] fl_addr
);
    localparam int CW = $clog2(T_WP + 2);

    logic [CW-1:0] low_cnt_q;

    always_ff @(posedge clk) begin
        if (rst || fl_we_n) begin
            low_cnt_q <= '0;
        end else if (low_cnt_q != CW'(T_WP + 1)) begin
            low_cnt_q <= low_cnt_q + CW'(1);
        end
    end

    // R1
    a_r1_idle_pins: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe));

    // R3
    a_r3_we_needs_ce: assert property (@(posedge clk) disable iff (rst)
        !fl_we_n |-> !fl_ce_n);

    // R3
    a_r3_addr_held_low: assert property (@(posedge clk) disable iff (rst)
        (!fl_we_n && $past(!fl_we_n)) |-> $stable(fl_addr));

    // R3
    a_r3_we_width: assert property (@(posedge clk) disable iff (rst)
        $rose(fl_we_n) |-> (low_cnt_q == CW'(T_WP)));

    // R7
    a_r7_released_on_read: assert property (@(posedge clk) disable iff (rst)
        !fl_oe_n |-> (!fl_dq_oe && fl_we_n));

    // R9
    a_r9_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && !busy && !timeout));

    // R10
    a_r10_timeout_after_busy: assert property (@(posedge clk) disable iff (rst)
        timeout |-> ($past(busy) && !busy));
endmodule

bind pflash_wr_ctrl pflash_wr_ctrl_chk #(.T_WP(T_WP)) chk_i (
    .clk(clk), .rst(rst), .busy(busy), .done(done), .timeout(timeout),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_dq_oe(fl_dq_oe), .fl_addr(fl_addr)
);

// File: tb/pflash_wr_ctrl_tb_top.sv
module pflash_wr_ctrl_tb_top;
    localparam int H = 3, P = 4, G = 2, R = 7;
    localparam int TP = 63, TS = 150, TC = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [1:0] req_op = 2'd0;
    logic [15:0] req_addr = '0, req_data = '0;
    logic busy, done, timeout, fl_dq_oe, fl_ce_n, fl_oe_n, fl_we_n;
    logic [15:0] fl_addr, fl_dq_o;
    logic [15:0] fl_dq_i = 16'h1234;

    int vectors = 0, miscompares = 0;
    int fv[$];
    int rd_idx = 0;
    logic [38:0] expq[$];

    always #5 clk = ~clk;

    pflash_wr_ctrl #(.T_WPH(H), .T_WP(P), .T_RGAP(G), .T_RD(R), .SECTOR_AW(11),
                     .TO_PROG(TP), .TO_SECT(TS), .TO_CHIP(TC)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .timeout(timeout), .fl_addr(fl_addr), .fl_dq_o(fl_dq_o),
        .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i), .fl_ce_n(fl_ce_n),
        .fl_oe_n(fl_oe_n), .fl_we_n(fl_we_n)
    );

    function automatic int val(int k);
        if (fv.size() == 0) return 0;
        return (k < fv.size()) ? fv[k] : fv[fv.size() - 1];
    endfunction

    task automatic set_dq();
        fl_dq_i = 16'h1234 | ((val(rd_idx) != 0) ? 16'h0040 : 16'h0000);
    endtask

    // flash stand-in: each finished read advances to the next bit-6 value
    always @(posedge fl_oe_n) begin
        rd_idx = rd_idx + 1;
        set_dq();
    end

    function automatic logic [38:0] pk(logic b, logic d, logic t, logic ce, logic we,
                                      logic oe, logic dqoe, logic [15:0] a,
                                      logic [15:0] dq);
        return {b, d, t, ce, we, oe, dqoe, a, dq};
    endfunction

    task automatic check(logic [38:0] exp, string tag);
        logic [38:0] got;
        got = pk(busy, done, timeout, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, fl_addr, fl_dq_o);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h (busy,done,to,ce,we,oe,oe_dq,addr,dq)",
                     tag, got, exp);
        end
    endtask

    task automatic push_wr(logic [15:0] a, logic [15:0] d);
        repeat (H) expq.push_back(pk(1, 0, 0, 0, 1, 1, 1, a, d));
        repeat (P) expq.push_back(pk(1, 0, 0, 0, 0, 1, 1, a, d));
    endtask

    task automatic build(int op, logic [15:0] addr, logic [15:0] data, int limit);
        logic [15:0] pa;
        int t = 0, k = 0, st = 0, pv = 0, v;
        bit fin = 0, ok = 0;
        push_wr(16'h5555, 16'h00AA);
        push_wr(16'h2AAA, 16'h0055);
        if (op == 0) begin
            push_wr(16'h5555, 16'h00A0);
            push_wr(addr, data);
            pa = addr;
        end else begin
            push_wr(16'h5555, 16'h0080);
            push_wr(16'h5555, 16'h00AA);
            push_wr(16'h2AAA, 16'h0055);
            if (op == 1) begin
                pa = addr & 16'hF800;
                push_wr(pa, 16'h0030);
            end else begin
                pa = 16'h5555;
                push_wr(16'h5555, 16'h0010);
            end
        end
        while (!fin) begin
            for (int c = 0; c < G + R; c++) begin
                t++;
                expq.push_back(pk(1, 0, 0, 0, 1, (c < G), 0, pa, 16'h0000));
                if (c == G + R - 1) begin
                    v = val(k);
                    if (k > 0) st = (v == pv) ? st + 1 : 0;
                    pv = v;
                    k++;
                    if (st == 3) begin fin = 1; ok = 1; end
                end
                if (!fin && t == limit) fin = 1;
                if (fin) break;
            end
        end
        expq.push_back(pk(0, ok, !ok, 1, 1, 1, 0, 16'h0000, 16'h0000));
    endtask

    task automatic run_op(int op, logic [15:0] addr, logic [15:0] data, int limit,
                          string tag, bit inject);
        int n = 0;
        rd_idx = 0;
        set_dq();
        expq.delete();
        build(op, addr, data, limit);
        @(negedge clk);
        req_valid = 1'b1; req_op = 2'(op); req_addr = addr; req_data = data;
        @(negedge clk);
        req_valid = 1'b0;
        while (expq.size() > 0) begin
            check(expq.pop_front(), tag);
            if (inject && n == 5) begin
                req_valid = 1'b1; req_op = 2'd2; req_addr = 16'hFFFF; req_data = 16'h1111;
            end else begin
                req_valid = 1'b0;
            end
            n++;
            @(negedge clk);
        end
        req_valid = 1'b0;
        check(pk(0, 0, 0, 1, 1, 1, 0, 16'h0000, 16'h0000), {tag, " R9 single pulse"});
    endtask

    task automatic idle_check(int n, string tag);
        repeat (n) begin
            check(pk(0, 0, 0, 1, 1, 1, 0, 16'h0000, 16'h0000), tag);
            @(negedge clk);
        end
    endtask

    task automatic alt_fill();
        fv.delete();
        for (int i = 0; i < 60; i++) fv.push_back(i % 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: got hang expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        idle_check(3, "R1 reset state");

        fv = '{0, 0, 0, 0};
        run_op(0, 16'h1234, 16'hBEEF, TP, "R3 R4 R7 R8 R9 word write", 0);

        fv = '{0, 1, 1, 0, 0, 0, 0};
        run_op(0, 16'h0F0F, 16'h0000, TP, "R8 early pair then flip", 0);

        fv = '{1, 1, 1, 0, 0, 0, 0};
        run_op(0, 16'hFFFE, 16'h5A5A, TP, "R8 flip on last confirm", 0);

        fv = '{0, 1, 0, 1, 0, 0, 0, 0};
        run_op(1, 16'hBABE, 16'h0000, TS, "R5 R7 sector erase", 0);

        fv = '{1, 0, 1, 1, 1, 1};
        run_op(2, 16'h0000, 16'h0000, TC, "R6 R7 full erase", 0);

        fv = '{0, 1, 0, 1, 1, 1, 1};
        run_op(0, 16'h4000, 16'h0001, TP, "R10 settle on last cycle", 0);

        alt_fill();
        run_op(0, 16'h2222, 16'h3333, TP, "R10 word write timeout", 0);

        alt_fill();
        run_op(1, 16'h07FF, 16'h0000, TS, "R10 sector timeout", 0);

        alt_fill();
        run_op(2, 16'h0000, 16'h0000, TC, "R10 full erase timeout", 0);

        fv = '{0, 0, 0, 0};
        run_op(0, 16'h8001, 16'hC3C3, TP, "R2 request while busy", 1);

        @(negedge clk);
        req_valid = 1'b1; req_op = 2'd3; req_addr = 16'h5555; req_data = 16'h00AA;
        @(negedge clk);
        req_valid = 1'b0;
        idle_check(4, "R2 unused op code");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule